// File: doc/BRIEF.md
# Pushbutton Power Sequencer

This block is the control state machine that decides when two step-down regulators are enabled. A host controller raises or lowers one request line per rail. The first rising request, with a battery or a valid external supply present, takes the machine from off to the active state. While the machine is active, each rail enable follows its own request line. When both request lines have dropped, the machine disables both rails and enters a lockout. The lockout lasts a fixed number of millisecond ticks and ignores every wake source, so that the supplies the block generated can discharge fully before anything can restart them.

A pushbutton input is active low and arrives already synchronised. When the button has been held low long enough, the block drives an active-low status pulse to the host. The host then decides in software whether to power down. Timing comes from a 1 kHz enable tick. The tick is either supplied by the host and retimed by one register, or produced by an internal clock divider, as a parameter selects. The press threshold and the lockout length are parameters, so a simulation can use short values.

Top module: `pb_power_seq`

## Requirements
- R1: After reset both enables are low, the status output is high, and the machine is off.
- R2: When the machine is off and at least one supply flag is high, a rising edge on either request line moves it to active. On that same clock edge, each enable takes the value of its own request line.
- R3: While the machine is active, en1_o equals the value of req1_i at the previous clock edge, and en2_o equals the value of req2_i at the previous clock edge. The rails are independent of each other.
- R4: When the machine is active and both request lines are sampled low, it enters lockout on that clock edge, and both enables are low for the whole of the lockout.
- R5: The lockout lasts exactly LOCK_TICKS internal ticks and then returns the machine to off. The internal tick is tick_i delayed by one register.
- R6: During lockout, request edges, the pushbutton and a newly asserted supply flag have no effect: the enables stay low and the status output stays high. A request line held high across the end of the lockout does not wake the machine, because a fresh rising edge is required.
- R7: The button is sampled on internal ticks. When it has been sampled low on PRESS_TICKS consecutive ticks, pbstat_no goes low. pbstat_no returns high on the first tick at which the button is sampled high. A shorter press produces no pulse.
- R8: On any clock edge where both supply flags are low, the machine goes off and both enables drop.
- R9: Sequencing is the same whether the battery flag alone, the external flag alone, or both flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 kHz single-cycle enable from the host (used when external tick is selected) |
| req1_i | input | 1 | Host request for rail 1 |
| req2_i | input | 1 | Host request for rail 2 |
| btn_ni | input | 1 | Synchronised pushbutton, active low |
| bat_ok_i | input | 1 | Battery present flag |
| ext_ok_i | input | 1 | Valid external supply flag |
| en1_o | output | 1 | Rail 1 regulator enable |
| en2_o | output | 1 | Rail 2 regulator enable |
| pbstat_no | output | 1 | Pushbutton status pulse to host, active low |

## Verification
The bench stimulates the block from a clock-by-clock reference model and goes after the following corner cases.

- **Wake sources during lockout.** It applies request edges, a long press and a new external supply while the lockout is running. A design that leaked any of these would light a rail or pull the status line low early.
- **Request held through the end of lockout.** It keeps a request high across the end of the lockout. A level-triggered wake would power a rail back up on its own at that point.
- **Button presses near the threshold.** It uses presses just under and well over the threshold. An off-by-one press counter would pulse on the short press, or miss the long one by a tick.
- **Supply removal and supply combinations.** It removes the supply in the middle of operation and tries each supply combination. A design that latched the active state, or that looked at only one flag, would diverge from the model here.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_LOCK   = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pbseq_tick.sv
module pbseq_tick #(
  parameter bit          EXT_TICK   = 1'b1,
  parameter int unsigned DIV_CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic tick_o
);
  generate
    if (EXT_TICK) begin : g_ext
      logic tick_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tick_q <= 1'b0;
        else         tick_q <= tick_i;
      end
      assign tick_o = tick_q;
    end else begin : g_div
      localparam int unsigned W = (DIV_CYCLES > 1) ? $clog2(DIV_CYCLES) : 1;
      localparam logic [W-1:0] LAST = W'(DIV_CYCLES - 1);
      logic [W-1:0] cnt_q;
      logic         tick_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q  <= '0;
          tick_q <= 1'b0;
        end else begin
          tick_q <= (cnt_q == LAST);
          cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end
      assign tick_o = tick_q;
      logic unused_tick;
      assign unused_tick = tick_i;
    end
  endgenerate
endmodule

// File: rtl/pbseq_button.sv
module pbseq_button #(
  parameter int unsigned PRESS_TICKS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic btn_ni,
  input  logic lock_i,
  output logic pbstat_no
);
  localparam int unsigned CW = $clog2(PRESS_TICKS + 1);
  localparam logic [CW-1:0] PRESS_C = CW'(PRESS_TICKS);

  logic [CW-1:0] cnt_q;

  // saturating count of consecutive low samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (lock_i)  cnt_q <= '0;
    else if (tick_i) begin
      if (btn_ni)                cnt_q <= '0;
      else if (cnt_q != PRESS_C) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pbstat_no = (cnt_q != PRESS_C);

  p_pulse_on_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pbstat_no) |-> $past(tick_i))
    else $error("pbstat asserted off a tick");

  p_lock_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> pbstat_no)
    else $error("pbstat active during lockout");
endmodule

// File: rtl/pbseq_fsm.sv
module pbseq_fsm
  import pbseq_pkg::*;
#(
  parameter int unsigned LOCK_TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic req1_i,
  input  logic req2_i,
  input  logic supply_ok_i,
  output logic en1_o,
  output logic en2_o,
  output logic lock_o
);
  localparam int unsigned LW = (LOCK_TICKS > 1) ? $clog2(LOCK_TICKS) : 1;
  localparam logic [LW-1:0] LOCK_LAST = LW'(LOCK_TICKS - 1);

  pwr_state_e    state_q, state_d;
  logic [LW-1:0] lcnt_q, lcnt_d;
  logic [1:0]    req_prev_q, en_q;
  logic [1:0]    req, rise;

  assign req  = {req2_i, req1_i};
  assign rise = req & ~req_prev_q;

  always_comb begin
    state_d = state_q;
    lcnt_d  = lcnt_q;
    unique case (state_q)
      ST_OFF: begin
        if (supply_ok_i && (rise != 2'b00)) state_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (!supply_ok_i) state_d = ST_OFF;
        else if (req == 2'b00) begin
          state_d = ST_LOCK;
          lcnt_d  = '0;
        end
      end
      ST_LOCK: begin
        if (!supply_ok_i) state_d = ST_OFF;
        else if (tick_i) begin
          if (lcnt_q == LOCK_LAST) state_d = ST_OFF;
          else                     lcnt_d  = lcnt_q + 1'b1;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_OFF;
      lcnt_q     <= '0;
      req_prev_q <= '0;
      en_q       <= '0;
    end else begin
      state_q    <= state_d;
      lcnt_q     <= lcnt_d;
      req_prev_q <= req;
      en_q       <= (state_d == ST_ACTIVE) ? req : 2'b00;
    end
  end

  assign en1_o  = en_q[0];
  assign en2_o  = en_q[1];
  assign lock_o = (state_q == ST_LOCK);

  p_wake_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && supply_ok_i && rise != 2'b00) |=> (state_q == ST_ACTIVE))
    else $error("wake missed");

  p_follow1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE) |-> (en1_o == $past(req1_i)))
    else $error("en1 not following req1");

  p_follow2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE) |-> (en2_o == $past(req2_i)))
    else $error("en2 not following req2");

  p_lock_enter_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && supply_ok_i && !req1_i && !req2_i) |=> lock_o)
    else $error("lockout not entered");

  p_lock_dark_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> (!en1_o && !en2_o))
    else $error("rail enabled in lockout");

  p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && supply_ok_i && !tick_i) |=> lock_o)
    else $error("lockout left without tick");

  p_no_supply_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (state_q == ST_OFF && !en1_o && !en2_o))
    else $error("not off without supply");
endmodule

// File: rtl/pb_power_seq.sv
module pb_power_seq #(
  parameter bit          EXT_TICK    = 1'b1,
  parameter int unsigned DIV_CYCLES  = 100000,
  parameter int unsigned PRESS_TICKS = 50,
  parameter int unsigned LOCK_TICKS  = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic req1_i,
  input  logic req2_i,
  input  logic btn_ni,
  input  logic bat_ok_i,
  input  logic ext_ok_i,
  output logic en1_o,
  output logic en2_o,
  output logic pbstat_no
);
  logic tick, lock, supply_ok;

  assign supply_ok = bat_ok_i | ext_ok_i;

  pbseq_tick #(.EXT_TICK(EXT_TICK), .DIV_CYCLES(DIV_CYCLES)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .tick_o(tick)
  );

  pbseq_button #(.PRESS_TICKS(PRESS_TICKS)) u_btn (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .btn_ni   (btn_ni),
    .lock_i   (lock),
    .pbstat_no(pbstat_no)
  );

  pbseq_fsm #(.LOCK_TICKS(LOCK_TICKS)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .req1_i     (req1_i),
    .req2_i     (req2_i),
    .supply_ok_i(supply_ok),
    .en1_o      (en1_o),
    .en2_o      (en2_o),
    .lock_o     (lock)
  );
endmodule

// File: tb/sim_pb_power_seq.sv
`timescale 1ns/1ps
module sim_pb_power_seq;
  localparam int PRESS = 5;
  localparam int LOCK  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, req1 = 1'b0, req2 = 1'b0, btn_n = 1'b1, bat = 1'b0, ext = 1'b0;
  logic en1, en2, pbstat_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pb_power_seq #(.EXT_TICK(1'b1), .DIV_CYCLES(4), .PRESS_TICKS(PRESS), .LOCK_TICKS(LOCK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req1_i(req1), .req2_i(req2),
    .btn_ni(btn_n), .bat_ok_i(bat), .ext_ok_i(ext),
    .en1_o(en1), .en2_o(en2), .pbstat_no(pbstat_n)
  );

  // behavioural reference: 0 off, 1 active, 2 lockout
  int m_state, m_lcnt, m_pcnt;
  bit m_en1, m_en2, m_p1, m_p2, m_tick;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_lcnt = 0; m_pcnt = 0;
      m_en1 = 0; m_en2 = 0; m_p1 = 0; m_p2 = 0; m_tick = 0;
    end else begin
      int  ns, nl, np;
      bit  sup, wake;
      sup  = bat | ext;
      wake = (req1 && !m_p1) || (req2 && !m_p2);
      ns = m_state; nl = m_lcnt; np = m_pcnt;
      if (m_state == 2) np = 0;
      else if (m_tick) np = btn_n ? 0 : ((m_pcnt < PRESS) ? m_pcnt + 1 : PRESS);
      if (!sup) ns = 0;
      else if (m_state == 0 && wake) ns = 1;
      else if (m_state == 1 && !req1 && !req2) begin ns = 2; nl = 0; end
      else if (m_state == 2 && m_tick) begin
        if (m_lcnt == LOCK - 1) ns = 0; else nl = m_lcnt + 1;
      end
      m_en1 = (ns == 1) && req1;
      m_en2 = (ns == 1) && req2;
      m_state = ns; m_lcnt = nl; m_pcnt = np;
      m_p1 = req1; m_p2 = req2; m_tick = tick;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // clock-by-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 en1 vs model", en1, m_en1);
      chk("R3 en2 vs model", en2, m_en2);
      chk("R7 pbstat vs model", pbstat_n, (m_pcnt == PRESS) ? 0 : 1);
    end
  end

  // 1 kHz stand-in: one tick every 4 clocks
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      tick = (ph == 3);
      ph = (ph + 1) % 4;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(3);
    chk("R1 en1 reset", en1, 0);
    chk("R1 en2 reset", en2, 0);
    chk("R1 pbstat reset", pbstat_n, 1);
    rst_n = 1'b1;
    cyc(2);
    // no supply: request ignored
    req1 = 1; cyc(3);
    chk("R8 no supply wake", en1, 0);
    req1 = 0; cyc(2);
    // battery only wake
    bat = 1; cyc(2);
    req1 = 1; cyc(1);
    chk("R2 wake on req1", en1, 1);
    chk("R2 en2 stays low", en2, 0);
    cyc(5);
    req2 = 1; cyc(1);
    chk("R3 en2 follows", en2, 1);
    req1 = 0; cyc(1);
    chk("R3 en1 drops alone", en1, 0);
    chk("R3 en2 holds", en2, 1);
    req1 = 1; cyc(1);
    chk("R3 en1 back", en1, 1);
    // long press while active
    btn_n = 0; cyc(PRESS * 4 + 8);
    chk("R7 long press pulses", pbstat_n, 0);
    btn_n = 1; cyc(6);
    chk("R7 release ends pulse", pbstat_n, 1);
    // short press
    btn_n = 0; cyc((PRESS - 2) * 4); btn_n = 1; cyc(6);
    chk("R7 short press none", pbstat_n, 1);
    // power down to lockout
    req1 = 0; req2 = 0; cyc(1);
    chk("R4 en1 off", en1, 0);
    chk("R4 en2 off", en2, 0);
    cyc(8);
    req2 = 1; btn_n = 0; ext = 1; cyc(PRESS * 4 + 8);
    chk("R6 req ignored", en2, 0);
    chk("R6 button ignored", pbstat_n, 1);
    btn_n = 1; ext = 0;
    cyc(LOCK * 4);
    chk("R6 held req no wake", en2, 0);
    req2 = 0; cyc(2); req2 = 1; cyc(1);
    chk("R5 off after lockout", en2, 1);
    // supply loss in active
    bat = 0; cyc(1);
    chk("R8 supply loss", en2, 0);
    bat = 1; cyc(3);
    chk("R8 no rewake on return", en2, 0);
    req2 = 0; cyc(1);
    // external only
    bat = 0; ext = 1; cyc(LOCK * 4 + 8);
    req2 = 1; cyc(1);
    chk("R9 ext only wake", en2, 1);
    req2 = 0; cyc(LOCK * 4 + 12);
    // both supplies, quick lockout retry
    bat = 1;
    req1 = 1; cyc(1);
    chk("R9 both wake", en1, 1);
    req1 = 0; cyc(LOCK * 2);
    req1 = 1; cyc(1);
    chk("R5 still locked midway", en1, 0);
    req1 = 0; cyc(LOCK * 4);
    req1 = 1; cyc(1);
    chk("R5 wake after window", en1, 1);
    cyc(4);
    summary();
  end
endmodule